// File: doc/BRIEF.md
# Return Stack Fault Detector

This block holds the return addresses of a small processor core. A call or an interrupt entry pushes a program-counter value onto it, and a return pops the most recent one off. The core reads the value it will return to from the top-of-stack output, which is valid in the same cycle the pop is requested. An occupancy count reports how many entries are live, and a count of zero means the stack is empty.

Pushing onto a full stack and popping from an empty one are faults. Each fault sets a sticky flag of its own. A configuration input decides what else a fault does. It can leave the flag as the only record, or it can also send a one-cycle request to the chip's reset sequencer. That request is issued one cycle after the flag becomes visible.

A core reset from that sequencer empties the stack but leaves both flags as they were. Software can then read the cause of the reset. The flags clear only through a software clear strobe or a power-on reset.

Top module: `rstack_guard`

## Requirements
- R1: A push when fewer than DEPTH entries are live stores `push_pc` as the new top, and `level` rises by one at the next clock edge.
- R2: While `level` is not zero, `tos_pc` shows the most recently pushed live entry. A pop lowers `level` by one at the next edge, and the entry below then appears on `tos_pc`.
- R3: A push without a pop when `level` equals DEPTH sets `full_flag`. It leaves `level` and every stored entry unchanged.
- R4: A pop without a push when `level` is zero sets `under_flag`. `level` stays 0, and `tos_pc` reads zero whenever `level` is zero.
- R5: Both flags are sticky. A cycle with `flag_clr` high clears them at the next edge. A fault in the same cycle as `flag_clr` still leaves its flag set.
- R6: With `fault_rst_en` high in the fault cycle, `reset_req` is high for exactly one cycle. That cycle is the one after the matching flag first reads 1.
- R7: With `fault_rst_en` low in the fault cycle, the fault sets its flag and `reset_req` stays low.
- R8: `core_rst` high at a clock edge sets `level` to 0 and ignores any push or pop in that cycle. Both flags keep their values.
- R9: A push and a pop in the same cycle act as a pop followed by a push. On a non-empty stack, `level` is unchanged and the top is replaced by `push_pc`, with no fault even when the stack is full. On an empty stack, `under_flag` is set and `level` becomes 1, holding `push_pc`.
- R10: A low `por_n` clears `level`, both flags and `reset_req` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| core_rst | input | 1 | Synchronous core reset from the reset sequencer |
| fault_rst_en | input | 1 | 1: a fault also requests a reset |
| push_req | input | 1 | Push request (call or interrupt entry) |
| pop_req | input | 1 | Pop request (return) |
| push_pc | input | AW (21) | Value to push |
| flag_clr | input | 1 | Software strobe that clears both flags |
| tos_pc | output | AW (21) | Top live entry, zero when empty |
| level | output | PW (5) | Number of live entries |
| full_flag | output | 1 | Sticky push-on-full fault flag |
| under_flag | output | 1 | Sticky pop-on-empty fault flag |
| reset_req | output | 1 | One-cycle reset request pulse |

## Verification
The hardest state to reach is a completely full stack that is still taking traffic. Only from there can the bench see an overflow, a same-cycle push and pop that must not fault, and a fault that lands in the same cycle as a software clear. The stimulus gets there by pushing 31 distinct values from an empty stack. It then stays at the top and drives the overflow push, the combined push and pop, and the clear-plus-fault cycle in turn, checking the one-cycle reset pulse in the cycle after the flag. A core reset applied while a flag is set shows that the stack empties and the flag survives.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

   // Request decode, bit 1 = push, bit 0 = pop.
   typedef enum logic [1:0] {
      OP_IDLE = 2'b00,
      OP_POP  = 2'b01,
      OP_PUSH = 2'b10,
      OP_BOTH = 2'b11
   } rsg_op_e;

   // Events produced by the pointer unit for the flag unit.
   typedef struct packed {
      logic ovf;
      logic unf;
   } rsg_evt_t;

endpackage

// File: rtl/rsg_store.sv
module rsg_store #(
   parameter int DEPTH       = 31,
   parameter int AW          = 21,
   parameter int PW          = 5,
   parameter bit ENTRY_RESET = 1'b1
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          wr_en,
   input  logic [PW-1:0] wr_idx,
   input  logic [AW-1:0] wr_data,
   input  logic [PW-1:0] live_cnt,
   output logic [AW-1:0] tos
);

   logic [AW-1:0] ent_rd [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [AW-1:0] q;
      logic          hit;

      assign hit = wr_en && (wr_idx == PW'(i));

      if (ENTRY_RESET) begin : g_rst
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)   q <= '0;
            else if (hit) q <= wr_data;
         end
      end else begin : g_nrst
         always_ff @(posedge clk) begin
            if (hit) q <= wr_data;
         end
      end

      assign ent_rd[i] = q;
   end

   // Top of stack: entry live_cnt-1, zero when nothing is live.
   always_comb begin
      tos = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (live_cnt == PW'(k + 1)) tos = ent_rd[k];
      end
   end

endmodule

// File: rtl/rsg_ptr.sv
module rsg_ptr
   import rsg_pkg::*;
#(
   parameter int DEPTH = 31,
   parameter int PW    = 5
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          core_rst,
   input  logic          push,
   input  logic          pop,
   output logic [PW-1:0] cnt,
   output logic          wr_en,
   output logic [PW-1:0] wr_idx,
   output rsg_evt_t      evt
);

   localparam logic [PW-1:0] CNT_TOP = PW'(DEPTH);
   localparam logic [PW-1:0] ONE     = PW'(1);

   rsg_op_e       op;
   logic [PW-1:0] cnt_nxt;

   always_comb begin
      op      = core_rst ? OP_IDLE : rsg_op_e'({push, pop});
      cnt_nxt = cnt;
      wr_en   = 1'b0;
      wr_idx  = '0;
      evt     = '0;
      unique case (op)
         OP_PUSH: begin
            if (cnt == CNT_TOP) begin
               evt.ovf = 1'b1;
            end else begin
               wr_en   = 1'b1;
               wr_idx  = cnt;
               cnt_nxt = cnt + ONE;
            end
         end
         OP_POP: begin
            if (cnt == '0) evt.unf = 1'b1;
            else           cnt_nxt = cnt - ONE;
         end
         OP_BOTH: begin
            wr_en = 1'b1;
            if (cnt == '0) begin
               evt.unf = 1'b1;
               wr_idx  = '0;
               cnt_nxt = ONE;
            end else begin
               wr_idx  = cnt - ONE;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)        cnt <= '0;
      else if (core_rst) cnt <= '0;
      else               cnt <= cnt_nxt;
   end

endmodule

// File: rtl/rsg_flags.sv
module rsg_flags
   import rsg_pkg::*;
(
   input  logic     clk,
   input  logic     por_n,
   input  rsg_evt_t evt,
   input  logic     clr,
   input  logic     rst_en,
   output logic     full_flag,
   output logic     under_flag,
   output logic     reset_req
);

   logic req_stage;

   // Sticky flags: a fault in the clear cycle wins over the clear.
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         full_flag  <= 1'b0;
         under_flag <= 1'b0;
      end else begin
         full_flag  <= evt.ovf | (full_flag  & ~clr);
         under_flag <= evt.unf | (under_flag & ~clr);
      end
   end

   // Two registers: the flag shows first, the request one cycle later.
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         req_stage <= 1'b0;
         reset_req <= 1'b0;
      end else begin
         req_stage <= (evt.ovf | evt.unf) & rst_en;
         reset_req <= req_stage;
      end
   end

endmodule

// File: rtl/rstack_guard.sv
module rstack_guard
   import rsg_pkg::*;
#(
   parameter int DEPTH       = 31,
   parameter int AW          = 21,
   parameter bit ENTRY_RESET = 1'b1,
   localparam int PW         = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          core_rst,
   input  logic          fault_rst_en,
   input  logic          push_req,
   input  logic          pop_req,
   input  logic [AW-1:0] push_pc,
   input  logic          flag_clr,
   output logic [AW-1:0] tos_pc,
   output logic [PW-1:0] level,
   output logic          full_flag,
   output logic          under_flag,
   output logic          reset_req
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("rstack_guard: DEPTH must be at least 2");
   end
   if (AW < 1) begin : g_bad_aw
      $error("rstack_guard: AW must be at least 1");
   end

   logic          wr_en;
   logic [PW-1:0] wr_idx;
   rsg_evt_t      evt;

   rsg_ptr #(.DEPTH(DEPTH), .PW(PW)) u_ptr (
      .clk      (clk),
      .por_n    (por_n),
      .core_rst (core_rst),
      .push     (push_req),
      .pop      (pop_req),
      .cnt      (level),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .evt      (evt)
   );

   rsg_store #(.DEPTH(DEPTH), .AW(AW), .PW(PW), .ENTRY_RESET(ENTRY_RESET)) u_store (
      .clk      (clk),
      .por_n    (por_n),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_data  (push_pc),
      .live_cnt (level),
      .tos      (tos_pc)
   );

   rsg_flags u_flags (
      .clk        (clk),
      .por_n      (por_n),
      .evt        (evt),
      .clr        (flag_clr),
      .rst_en     (fault_rst_en),
      .full_flag  (full_flag),
      .under_flag (under_flag),
      .reset_req  (reset_req)
   );

endmodule

// File: rtl/rsg_chk.sv
module rsg_chk #(
   parameter int DEPTH = 31,
   parameter int AW    = 21,
   parameter int PW    = 5
) (
   input logic          clk,
   input logic          por_n,
   input logic          core_rst,
   input logic          fault_rst_en,
   input logic          push_req,
   input logic          pop_req,
   input logic [AW-1:0] push_pc,
   input logic          flag_clr,
   input logic [AW-1:0] tos_pc,
   input logic [PW-1:0] level,
   input logic          full_flag,
   input logic          under_flag,
   input logic          reset_req
);

   localparam logic [PW-1:0] TOP = PW'(DEPTH);

   a_r1_push_grows: assert property (@(posedge clk) disable iff (!por_n)
      push_req && !pop_req && !core_rst && level < TOP
      |=> level == $past(level) + PW'(1) && tos_pc == $past(push_pc));

   a_r2_pop_shrinks: assert property (@(posedge clk) disable iff (!por_n)
      pop_req && !push_req && !core_rst && level != '0
      |=> level == $past(level) - PW'(1));

   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!por_n)
      push_req && !pop_req && !core_rst && level == TOP
      |=> full_flag && level == TOP && $stable(tos_pc));

   a_r4_no_underflow: assert property (@(posedge clk) disable iff (!por_n)
      pop_req && !push_req && !core_rst && level == '0
      |=> under_flag && level == '0);

   a_r4_empty_zero: assert property (@(posedge clk) disable iff (!por_n)
      level == '0 |-> tos_pc == '0);

   a_r5_full_sticky: assert property (@(posedge clk) disable iff (!por_n)
      full_flag && !flag_clr |=> full_flag);

   a_r5_under_sticky: assert property (@(posedge clk) disable iff (!por_n)
      under_flag && !flag_clr |=> under_flag);

   a_r5_clear: assert property (@(posedge clk) disable iff (!por_n)
      flag_clr && !push_req && !pop_req |=> !full_flag && !under_flag);

   a_r6_req_follows: assert property (@(posedge clk) disable iff (!por_n)
      ($rose(full_flag) || $rose(under_flag)) && $past(fault_rst_en) |=> reset_req);

   a_r7_req_gated: assert property (@(posedge clk) disable iff (!por_n)
      reset_req |-> $past(fault_rst_en, 2));

   a_r8_core_rst: assert property (@(posedge clk) disable iff (!por_n)
      core_rst && !flag_clr
      |=> level == '0 && full_flag == $past(full_flag) && under_flag == $past(under_flag));

   a_r9_replace: assert property (@(posedge clk) disable iff (!por_n)
      push_req && pop_req && !core_rst && level != '0
      |=> level == $past(level) && tos_pc == $past(push_pc));

   a_level_bound: assert property (@(posedge clk) disable iff (!por_n)
      level <= TOP);

endmodule

bind rstack_guard rsg_chk #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_rsg_chk (
   .clk          (clk),
   .por_n        (por_n),
   .core_rst     (core_rst),
   .fault_rst_en (fault_rst_en),
   .push_req     (push_req),
   .pop_req      (pop_req),
   .push_pc      (push_pc),
   .flag_clr     (flag_clr),
   .tos_pc       (tos_pc),
   .level        (level),
   .full_flag    (full_flag),
   .under_flag   (under_flag),
   .reset_req    (reset_req)
);

// File: tb/rstack_guard_tb.sv
module rstack_guard_tb;

   localparam int DEPTH = 31;
   localparam int AW    = 21;
   localparam int PW    = 5;

   logic          clk = 1'b0;
   logic          por_n = 1'b0;
   logic          core_rst = 1'b0;
   logic          fault_rst_en = 1'b0;
   logic          push_req = 1'b0;
   logic          pop_req = 1'b0;
   logic [AW-1:0] push_pc = '0;
   logic          flag_clr = 1'b0;
   logic [AW-1:0] tos_pc;
   logic [PW-1:0] level;
   logic          full_flag;
   logic          under_flag;
   logic          reset_req;

   always #2 clk = ~clk;

   rstack_guard #(.DEPTH(DEPTH), .AW(AW)) u_dut (
      .clk(clk), .por_n(por_n), .core_rst(core_rst), .fault_rst_en(fault_rst_en),
      .push_req(push_req), .pop_req(pop_req), .push_pc(push_pc), .flag_clr(flag_clr),
      .tos_pc(tos_pc), .level(level), .full_flag(full_flag),
      .under_flag(under_flag), .reset_req(reset_req)
   );

   typedef struct {
      int            due;
      string         tag;
      int            lvl;
      logic [AW-1:0] tos;
      bit            ff;
      bit            uf;
      bit            rq;
   } exp_t;

   exp_t sbq[$];
   exp_t mon_e;
   int   total = 0;
   int   bad   = 0;
   int   cyc   = 0;

   // Reference model state, written from the requirements.
   int            m_lvl = 0;
   logic [AW-1:0] m_stk [DEPTH];
   bit            m_ff = 0, m_uf = 0, m_stg = 0, m_rq = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string tag, input string what, input int act, input int expv);
      total++;
      if (act != expv) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   // Monitor: compares each expected record in the cycle it falls due.
   always @(negedge clk) begin
      while (sbq.size() > 0 && sbq[0].due <= cyc) begin
         mon_e = sbq.pop_front();
         chk(mon_e.tag, "level", int'(level), mon_e.lvl);
         chk(mon_e.tag, "tos_pc", int'(tos_pc), int'(mon_e.tos));
         chk(mon_e.tag, "full_flag", int'(full_flag), int'(mon_e.ff));
         chk(mon_e.tag, "under_flag", int'(under_flag), int'(mon_e.uf));
         chk(mon_e.tag, "reset_req", int'(reset_req), int'(mon_e.rq));
      end
   end

   // Driver: applies one cycle of stimulus and queues the expected result.
   task automatic step(input bit ps, input bit pp, input logic [AW-1:0] pc,
                       input bit clr, input bit dv, input bit en, input string tag);
      bit   ovf;
      bit   unf;
      exp_t e;
      ovf = 0;
      unf = 0;
      @(negedge clk);
      push_req = ps; pop_req = pp; push_pc = pc;
      flag_clr = clr; core_rst = dv; fault_rst_en = en;
      if (dv) begin
         m_lvl = 0;
      end else if (ps && pp) begin
         if (m_lvl == 0) begin unf = 1; m_stk[0] = pc; m_lvl = 1; end
         else m_stk[m_lvl-1] = pc;
      end else if (ps) begin
         if (m_lvl == DEPTH) ovf = 1;
         else begin m_stk[m_lvl] = pc; m_lvl++; end
      end else if (pp) begin
         if (m_lvl == 0) unf = 1;
         else m_lvl--;
      end
      m_rq  = m_stg;
      m_stg = (ovf | unf) & en;
      m_ff  = ovf | (m_ff & !clr);
      m_uf  = unf | (m_uf & !clr);
      e.due = cyc + 1;
      e.tag = tag;
      e.lvl = m_lvl;
      e.tos = (m_lvl == 0) ? '0 : m_stk[m_lvl-1];
      e.ff  = m_ff;
      e.uf  = m_uf;
      e.rq  = m_rq;
      sbq.push_back(e);
   endtask

   task automatic idle(input string tag);
      step(0, 0, '0, 0, 0, 0, tag);
   endtask

   task automatic por_check(input string tag);
      @(negedge clk);
      @(negedge clk);
      por_n = 1'b0;
      #1;
      chk(tag, "level", int'(level), 0);
      chk(tag, "full_flag", int'(full_flag), 0);
      chk(tag, "under_flag", int'(under_flag), 0);
      chk(tag, "reset_req", int'(reset_req), 0);
      chk(tag, "tos_pc", int'(tos_pc), 0);
      m_lvl = 0; m_ff = 0; m_uf = 0; m_stg = 0; m_rq = 0;
      @(negedge clk);
      por_n = 1'b1;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R10: outputs cleared while power-on reset is held.
      repeat (3) @(negedge clk);
      chk("R10", "level", int'(level), 0);
      chk("R10", "full_flag", int'(full_flag), 0);
      chk("R10", "under_flag", int'(under_flag), 0);
      chk("R10", "reset_req", int'(reset_req), 0);
      por_n = 1'b1;

      // R1 / R2: ordinary pushes and pops.
      for (int i = 0; i < 5; i++) step(1, 0, AW'(32'h1000 + i * 3), 0, 0, 1, "R1");
      step(0, 1, '0, 0, 0, 1, "R2");
      step(0, 1, '0, 0, 0, 1, "R2");
      // R9: push and pop together on a non-empty stack.
      step(1, 1, AW'(32'h1ABCD), 0, 0, 1, "R9");
      for (int i = 0; i < 3; i++) step(0, 1, '0, 0, 0, 1, "R2");

      // R4 / R7: pop on empty without reset enable.
      step(0, 1, '0, 0, 0, 0, "R4");
      idle("R7");
      idle("R7");
      // R5: software clear.
      step(0, 0, '0, 1, 0, 0, "R5");

      // R3 / R6: fill, then overflow with reset enable.
      for (int i = 0; i < DEPTH; i++) step(1, 0, AW'(32'h0F000 + i * 7), 0, 0, 1, "R1");
      step(1, 0, AW'(32'h1FFFF), 0, 0, 1, "R3");
      idle("R6");
      idle("R6");
      idle("R6");
      // R9: push and pop together on a full stack, no fault.
      step(1, 1, AW'(32'h0AAAA), 0, 0, 1, "R9");
      idle("R9");
      idle("R9");
      // R5: fault in the clear cycle keeps the flag.
      step(1, 0, AW'(32'h05555), 1, 0, 0, "R5");
      idle("R5");
      step(0, 0, '0, 1, 0, 0, "R5");
      // R7: overflow with reset disabled.
      step(1, 0, AW'(32'h03333), 0, 0, 0, "R7");
      idle("R7");
      idle("R7");

      // R8: core reset empties the stack, ignores a push, keeps the flag.
      step(1, 0, AW'(32'h07777), 0, 1, 1, "R8");
      idle("R8");
      // R9: push and pop together on an empty stack.
      step(1, 1, AW'(32'h12345), 0, 0, 1, "R9");
      idle("R6");
      idle("R6");
      idle("R9");

      // R10: power-on reset in the middle of a run.
      por_check("R10");
      step(1, 0, AW'(32'h00042), 0, 0, 0, "R1");
      idle("R2");
      idle("R2");
      repeat (3) @(negedge clk);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule